// File: doc/BRIEF.md
# Smart Card Clock and Bit-Timing Generator

This block turns a peripheral clock into the serial clock that feeds a smart card and into the elementary bit timing of the card link. A divider value and a two-bit prescaler select set the length of one card-clock half-period. One data bit is always a fixed count of 372 card-clock periods, so the bit rate follows the card clock. With a divider of zero and no prescaling, a 7.1424 MHz peripheral clock gives 9600 bit/s and a 14.2848 MHz clock gives 19200 bit/s.

The block also controls the card clock pin. The pin can be released to a general-purpose port, driven with the running clock, or parked at a steady low or high level. Stops and restarts are glitch-free. A stop request lets the current phase end at the parked level. A restart holds the parked level for one full half-period before the first edge. No high or low phase is ever shorter than a half-period, so the duty cycle stays at 50%. A one-cycle strobe marks the end of every bit. The bit count restarts whenever the clock is stopped.

Top module: `sc_cardclk_gen`

## Requirements
- R1: After reset the card clock is stopped at level 0, the bit strobe is 0 and the bit count is cleared. With the control inputs at 0, `card_clk_oe` is 0.
- R2: While running, every card-clock phase lasts H = (div_n+1) × 4^pre_sel peripheral cycles, which gives a 50% duty cycle.
- R3: While running, `bit_tick` is high for exactly one cycle every 744 × H cycles. It coincides with a card-clock edge.
- R4: When the clock is stopped and either `sc_mode`=0, or `sc_mode`=1 with `out_sel`=0 and `clk_run`=0, `card_clk_oe` is 0 and the pin is released to the port.
- R5: With `sc_mode`=1, `out_sel`=1, `park_hi`=0 and `clk_run`=0, the pin is driven (`card_clk_oe`=1) and settles at 0.
- R6: With `sc_mode`=1, `out_sel`=1, `park_hi`=1 and `clk_run`=0, the pin is driven and settles at 1.
- R7: With `sc_mode`=1 and `clk_run`=1, the pin is driven with the running clock whatever `out_sel` and `park_hi` hold.
- R8: When `clk_run` falls, the clock stops at once if it is already at the parked level. Otherwise it finishes the current phase, takes the parked level and holds it. No phase is cut short.
- R9: On a restart, the parked level is held for exactly H cycles after the start edge before the first toggle.
- R10: The bit count restarts while the clock is stopped. The first `bit_tick` after a restart appears 744 × H cycles after the start edge.
- R11: With div_n=0 and pre_sel=0, one bit lasts 744 peripheral cycles. That is 9600 bit/s at 7.1424 MHz and 19200 bit/s at 14.2848 MHz.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| div_n | input | DIV_W | Divider value; the half-period scales with div_n+1 |
| pre_sel | input | PRE_W | Prescaler select; the half-period scales with 4^pre_sel |
| sc_mode | input | 1 | Smart-card mode enable |
| out_sel | input | 1 | 1: the block keeps driving the pin when stopped; 0: the pin is released to the port when stopped |
| park_hi | input | 1 | Parked level when `out_sel`=1 (0 low, 1 high) |
| clk_run | input | 1 | 1: card clock runs; 0: stop request |
| card_clk | output | 1 | Card clock pin value |
| card_clk_oe | output | 1 | 1: the block drives the pin; 0: the pin belongs to the port |
| bit_tick | output | 1 | One-cycle strobe at the end of each bit period |

## Verification
Three properties are checked on every cycle. No running phase ends before H cycles. The bit strobe is a single-cycle pulse that lands on a card-clock edge and never appears while stopped. The pin is released or parked at the right level for each stopped configuration. The exact phase length after a restart, the stop behaviour that depends on the current level, the 744 × H bit spacing and the 9600/19200 bit/s checkpoints can only be shown by the bench scenarios. These compare a cycle-level behavioural model against the pin on every clock and also time the intervals directly.

// File: rtl/sc_clk_pkg.sv
package sc_clk_pkg;

    // Card-clock half-periods in one bit (372 full periods).
    localparam int unsigned BIT_HALVES = 744;

    typedef enum logic {
        CK_PARKED  = 1'b0,
        CK_RUNNING = 1'b1
    } ck_state_e;

    typedef struct packed {
        logic run_req;    // clock should run
        logic park_lvl;   // level held while stopped
        logic hold_drive; // keep driving the pin while stopped
    } pin_ctl_t;

    // Half-period length in peripheral cycles: (div+1) * 4^pre
    function automatic int unsigned half_cycles(int unsigned div, int unsigned pre);
        return (div + 1) << (2 * pre);
    endfunction

    function automatic pin_ctl_t decode_ctl(logic smif, logic osel, logic phi, logic run);
        pin_ctl_t c;
        c.run_req    = smif & run;
        c.hold_drive = smif & osel;
        c.park_lvl   = smif & osel & phi;
        return c;
    endfunction

endpackage

// File: rtl/sc_half_timer.sv
module sc_half_timer #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             enable,
    input  logic [CNT_W-1:0] half,
    output logic             wrap
);
    logic [CNT_W-1:0] hcnt;
    logic [CNT_W:0]   next_cnt;

    assign next_cnt = {1'b0, hcnt} + 1'b1;
    assign wrap     = enable && (next_cnt >= {1'b0, half});

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            hcnt <= '0;
        end else if (enable) begin
            hcnt <= wrap ? '0 : next_cnt[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/sc_clk_park.sv
module sc_clk_park
    import sc_clk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic run_req,
    input  logic park_lvl,
    input  logic wrap,
    output logic clk_lvl,
    output logic running,
    output logic stop_now,
    output logic toggle
);
    ck_state_e state;

    assign running  = (state == CK_RUNNING);
    assign stop_now = running && !run_req && (clk_lvl == park_lvl);
    assign toggle   = running && !stop_now && wrap;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= CK_PARKED;
            clk_lvl <= 1'b0;
        end else begin
            unique case (state)
                CK_RUNNING: begin
                    if (stop_now) begin
                        state <= CK_PARKED;
                    end else if (toggle) begin
                        clk_lvl <= ~clk_lvl;
                    end
                end
                CK_PARKED: begin
                    if (run_req) begin
                        state <= CK_RUNNING;
                    end else begin
                        clk_lvl <= park_lvl;
                    end
                end
                default: state <= CK_PARKED;
            endcase
        end
    end
endmodule

// File: rtl/sc_bit_timer.sv
module sc_bit_timer #(
    parameter int HALVES = 744,
    localparam int CNT_W = $clog2(HALVES)
) (
    input  logic clk,
    input  logic rst,
    input  logic running,
    input  logic toggle,
    output logic bit_tick
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALVES - 1);

    logic [CNT_W-1:0] edges;

    always_ff @(posedge clk) begin
        if (rst || !running) begin
            edges    <= '0;
            bit_tick <= 1'b0;
        end else begin
            bit_tick <= toggle && (edges == LAST);
            if (toggle) begin
                edges <= (edges == LAST) ? '0 : edges + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sc_cardclk_gen.sv
module sc_cardclk_gen
    import sc_clk_pkg::*;
#(
    parameter int DIV_W  = 8,
    parameter int PRE_W  = 2,
    parameter int HALVES = BIT_HALVES,
    localparam int HALF_W = DIV_W + 1 + 2 * ((1 << PRE_W) - 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_n,
    input  logic [PRE_W-1:0] pre_sel,
    input  logic             sc_mode,
    input  logic             out_sel,
    input  logic             park_hi,
    input  logic             clk_run,
    output logic             card_clk,
    output logic             card_clk_oe,
    output logic             bit_tick
);
    pin_ctl_t          ctl;
    logic [HALF_W-1:0] half;
    logic              wrap, running, stop_now, toggle, clk_lvl;

    assign ctl  = decode_ctl(sc_mode, out_sel, park_hi, clk_run);
    assign half = HALF_W'(half_cycles(32'(div_n), 32'(pre_sel)));

    sc_half_timer #(.CNT_W(HALF_W)) u_half (
        .clk    (clk),
        .rst    (rst),
        .clear  (!running || stop_now),
        .enable (running && !stop_now),
        .half   (half),
        .wrap   (wrap)
    );

    sc_clk_park u_park (
        .clk      (clk),
        .rst      (rst),
        .run_req  (ctl.run_req),
        .park_lvl (ctl.park_lvl),
        .wrap     (wrap),
        .clk_lvl  (clk_lvl),
        .running  (running),
        .stop_now (stop_now),
        .toggle   (toggle)
    );

    sc_bit_timer #(.HALVES(HALVES)) u_bit (
        .clk      (clk),
        .rst      (rst),
        .running  (running),
        .toggle   (toggle),
        .bit_tick (bit_tick)
    );

    assign card_clk    = clk_lvl;
    assign card_clk_oe = running || ctl.hold_drive;
endmodule

// File: rtl/sc_cardclk_chk.sv
module sc_cardclk_chk #(
    parameter int DIV_W = 8,
    parameter int PRE_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic [DIV_W-1:0] div_n,
    input logic [PRE_W-1:0] pre_sel,
    input logic             sc_mode,
    input logic             out_sel,
    input logic             park_hi,
    input logic             clk_run,
    input logic             card_clk,
    input logic             card_clk_oe,
    input logic             bit_tick,
    input logic             run_q
);
    logic [31:0] seg_len;
    logic        prev_clk, prev_run;
    logic [31:0] half_now;

    assign half_now = sc_clk_pkg::half_cycles(32'(div_n), 32'(pre_sel));

    always_ff @(posedge clk) begin
        if (rst) begin
            seg_len  <= 32'd1;
            prev_clk <= 1'b0;
            prev_run <= 1'b0;
        end else begin
            prev_clk <= card_clk;
            prev_run <= run_q;
            if (card_clk != prev_clk) seg_len <= 32'd1;
            else if (seg_len != '1)   seg_len <= seg_len + 1'b1;
        end
    end

    // R2
    min_phase_chk: assert property (@(posedge clk) disable iff (rst)
        (prev_run && run_q && card_clk != prev_clk) |-> (seg_len >= half_now));

    // R3
    tick_single_chk: assert property (@(posedge clk) disable iff (rst)
        bit_tick |=> !bit_tick);

    // R3
    tick_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
        bit_tick |-> (card_clk != prev_clk));

    // R10
    tick_stopped_chk: assert property (@(posedge clk) disable iff (rst)
        !run_q |-> !bit_tick);

    // R4
    released_chk: assert property (@(posedge clk) disable iff (rst)
        (!run_q && (!sc_mode || (!out_sel && !clk_run))) |-> !card_clk_oe);

    // R5
    park_low_chk: assert property (@(posedge clk) disable iff (rst)
        (!run_q && sc_mode && out_sel && !park_hi && !clk_run) |=> !card_clk);

    // R6
    park_high_chk: assert property (@(posedge clk) disable iff (rst)
        (!run_q && sc_mode && out_sel && park_hi && !clk_run) |=> card_clk);

    // R7
    drive_run_chk: assert property (@(posedge clk) disable iff (rst)
        run_q |-> card_clk_oe);
endmodule

bind sc_cardclk_gen sc_cardclk_chk #(.DIV_W(DIV_W), .PRE_W(PRE_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .div_n       (div_n),
    .pre_sel     (pre_sel),
    .sc_mode     (sc_mode),
    .out_sel     (out_sel),
    .park_hi     (park_hi),
    .clk_run     (clk_run),
    .card_clk    (card_clk),
    .card_clk_oe (card_clk_oe),
    .bit_tick    (bit_tick),
    .run_q       (running)
);

// File: tb/sc_cardclk_gen_test.sv
module sc_cardclk_gen_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;
    localparam int HALVES     = 744;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] div_n = '0;
    logic [1:0] pre_sel = '0;
    logic       sc_mode = 1'b0, out_sel = 1'b0, park_hi = 1'b0, clk_run = 1'b0;
    logic       card_clk, card_clk_oe, bit_tick;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    // behavioural reference state
    bit m_run = 1'b0, m_lvl = 1'b0, m_tick = 1'b0;
    int m_left = 0, m_edges = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sc_cardclk_gen uut (
        .clk(clk), .rst(rst), .div_n(div_n), .pre_sel(pre_sel),
        .sc_mode(sc_mode), .out_sel(out_sel), .park_hi(park_hi), .clk_run(clk_run),
        .card_clk(card_clk), .card_clk_oe(card_clk_oe), .bit_tick(bit_tick)
    );

    function automatic int half_len();
        return (int'(div_n) + 1) * (4 ** int'(pre_sel));
    endfunction

    task automatic check(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at t=%0t", req, what, act, exp, $time);
        end
    endtask

    // reference model, one step per rising edge
    always @(posedge clk) begin
        bit req, park;
        req  = sc_mode && clk_run;
        park = sc_mode && out_sel && park_hi;
        if (rst) begin
            m_run = 0; m_lvl = 0; m_left = 0; m_edges = 0; m_tick = 0;
        end else begin
            m_tick = 0;
            if (m_run) begin
                if (!req && m_lvl == park) begin
                    m_run = 0;
                    m_edges = 0;
                end else begin
                    m_left--;
                    if (m_left == 0) begin
                        m_lvl = !m_lvl;
                        m_left = half_len();
                        m_edges++;
                        if (m_edges == HALVES) begin
                            m_tick = 1;
                            m_edges = 0;
                        end
                    end
                end
            end else begin
                m_edges = 0;
                if (req) begin
                    m_run = 1;
                    m_left = half_len();
                end else begin
                    m_lvl = park;
                end
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R8", int'(card_clk), int'(m_lvl), "pin level vs model");
            check("R4", int'(card_clk_oe), int'(m_run || (sc_mode && out_sel)), "pin enable vs model");
            check("R3", int'(bit_tick), int'(m_tick), "bit strobe vs model");
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic cycles(int k);
        for (int i = 0; i < k; i++) @(negedge clk);
    endtask

    task automatic until_clk_change(output int cnt);
        logic start;
        start = card_clk;
        cnt = 0;
        do begin
            @(negedge clk);
            cnt++;
        end while (card_clk == start && cnt < 100000);
    endtask

    task automatic until_tick(output int cnt);
        cnt = 0;
        do begin
            @(negedge clk);
            cnt++;
        end while (!bit_tick && cnt < 100000);
    endtask

    initial begin
        int n;
        cycles(3);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1", int'(card_clk), 0, "clock after reset");
        check("R1", int'(card_clk_oe), 0, "enable after reset");
        check("R1", int'(bit_tick), 0, "strobe after reset");

        // R4: port released in card mode, stopped
        sc_mode = 1; out_sel = 0; park_hi = 0; clk_run = 0;
        cycles(2);
        check("R4", int'(card_clk_oe), 0, "port released");

        // R5: parked low
        out_sel = 1;
        cycles(2);
        check("R5", int'(card_clk_oe), 1, "driven when parked low");
        check("R5", int'(card_clk), 0, "parked low level");

        // R6: parked high
        park_hi = 1;
        cycles(2);
        check("R6", int'(card_clk_oe), 1, "driven when parked high");
        check("R6", int'(card_clk), 1, "parked high level");

        // R9 / R2 / R7: restart from high with H=12, park bits still high
        div_n = 8'd2; pre_sel = 2'd1; clk_run = 1;
        until_clk_change(n);
        check("R9", n, 12 + 1, "first phase after restart (+1 sample offset)");
        until_clk_change(n);
        check("R2", n, 12, "low phase length");
        check("R7", int'(card_clk), 1, "running despite park high");
        check("R7", int'(card_clk_oe), 1, "driven while running");

        // R8: stop request just after a rising edge, park low
        clk_run = 0; park_hi = 0;
        until_clk_change(n);
        check("R8", n, 12, "high phase completed before parking");
        check("R8", int'(card_clk), 0, "parked at low");
        cycles(36);
        check("R8", int'(card_clk), 0, "held low after stop");
        check("R10", int'(bit_tick), 0, "no strobe while stopped");

        // R10 / R3 / R11: H=1, bit = 744 cycles
        div_n = 0; pre_sel = 0; clk_run = 1;
        until_tick(n);
        check("R10", n, HALVES + 1, "first strobe after restart (+1 sample offset)");
        until_tick(n);
        check("R3", n, HALVES, "strobe spacing at H=1");
        check("R11", 7142400 / n, 9600, "bit rate at 7.1424 MHz");
        check("R11", 14284800 / n, 19200, "bit rate at 14.2848 MHz");
        check("R11", 7142400 % n, 0, "exact rate at 7.1424 MHz");

        // stop, switch to H=64 while stopped, restart
        clk_run = 0;
        cycles(4);
        pre_sel = 2'd3; clk_run = 1;
        until_clk_change(n);
        check("R9", n, 64 + 1, "first phase at H=64");
        until_clk_change(n);
        check("R2", n, 64, "phase at H=64");
        until_tick(n);
        check("R10", n, HALVES * 64 - 128, "remaining cycles to first strobe at H=64");

        // R4: card mode off stops the clock and releases the pin
        sc_mode = 0;
        cycles(2 * 64 + 4);
        check("R4", int'(card_clk_oe), 0, "released with card mode off");
        check("R4", int'(card_clk), 0, "stopped low with card mode off");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule